// File: doc/BRIEF.md
# Event Readout and Interrupt Controller

This block is the command side of an event data buffer on a crate backplane. A host issues a function code and a subaddress with a one-cycle strobe. The block decodes the pair and then does one of four things: it reads a buffered event word, reads or writes a configuration register, pulses a pedestal-memory write, or acts on the interrupt logic. It answers each command with a Q acknowledge and read data. Both appear in the cycle after the strobe.

An event processor upstream pushes words into the buffer and pulses `event_done` when an event is complete. That pulse raises a look-at-me interrupt. The interrupt drops on the first advancing read. If the extended strap is set, it stays up until the buffer drains instead. A mask gates the interrupt pin. An enable command starts a data-taking cycle: it clears the buffer and the interrupt and raises `busy` until `event_done` arrives.

Top module: `evt_readout_ctrl`

## Requirements
- R1: F0 A0 returns the head word with Q=1 when the buffer holds data, and the word count does not change.
- R2: F2 A0 returns the head word with Q=1, moves to the next word and lowers the remaining count by one.
- R3: A data read (F0 A0 or F2 A0) on an empty buffer returns 0 with Q=0 and moves nothing.
- R4: F16 A1, A2 and A3 write the 4-bit edge size, the 16-bit threshold and the 5-bit control word (low bits of the write data) with Q=1. F2 A1 and F2 A2 read edge size and threshold back. F1 with A0..A3 reads back control word, edge size, threshold and count with Q=1 always. Any F2 read gives Q=1 only when the buffer is not empty.
- R5: F2 A3 returns the number of words still in the buffer.
- R6: `event_done` sets the interrupt. In normal mode the first F2 A0 that returns data clears it, and so does F10 A0.
- R7: With `ext_lam_sel`=1 the interrupt stays set until the read that takes the last word, and F10 A0 does nothing.
- R8: F24 A0 masks the `lam` pin and F26 A0 unmasks it. The mask is set out of reset. F8 A0 gives Q=1 only when the interrupt is set and unmasked. F27 A0 gives Q=1 whenever it is set, whatever the mask.
- R9: F26 A4 raises `busy` and empties the buffer and the interrupt. `event_done` lowers `busy`.
- R10: `crate_clear` or F9 A0 empties the buffer, clears the interrupt and returns the pedestal address to 0. `busy` is left as it is.
- R11: `crate_init` does all that R10 does, and also lowers `busy` and sets the mask.
- R12: F16 A0 drives `ped_we` high during the strobe cycle. `ped_addr` counts 0,1,2,... from the last clear and `ped_wdata` is the low 12 bits of the write data. Q=1.
- R13: Any other function/subaddress pair gives Q=0 and read data 0, and changes no state. Q is 0 in every cycle that does not follow a strobe.
- R14: After reset, `rd_data`, `q_resp`, `lam`, `busy` and all configuration fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_strobe | input | 1 | Command valid for one cycle |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress |
| wr_data | input | 16 | Write data |
| crate_clear | input | 1 | Crate clear pulse |
| crate_init | input | 1 | Crate initialize pulse |
| ext_lam_sel | input | 1 | Extended interrupt strap |
| fill_valid | input | 1 | Event word push |
| fill_word | input | 16 | Event word |
| event_done | input | 1 | Event processing complete pulse |
| rd_data | output | 16 | Read data, valid the cycle after a strobe |
| q_resp | output | 1 | Q acknowledge, the cycle after a strobe |
| lam | output | 1 | Masked look-at-me interrupt |
| busy | output | 1 | Data-taking in progress |
| ped_we | output | 1 | Pedestal write enable |
| ped_addr | output | 10 | Pedestal write address |
| ped_wdata | output | 12 | Pedestal write value |
| cfg_edge | output | 4 | Edge size |
| cfg_thresh | output | 16 | Threshold |
| cfg_ctrl | output | 5 | Control word |

## Verification
Read data and Q are registered, so each is due on the first clock edge after the strobe edge. The bench samples them on the falling edge that follows. The interrupt, busy, count and configuration outputs also change on the edge that takes a command or pulse, and they are checked on the same falling edge. The pedestal write strobe and address are combinational, so they are checked within the strobe cycle itself, just after the inputs are driven. A scoreboard queues one expected response per strobe. The monitor takes an entry off the queue only in the cycle after a registered strobe, so a reply that comes early or late fails the comparison.

// File: rtl/erc_pkg.sv
package erc_pkg;

  typedef enum logic [4:0] {
    CMD_NONE,
    CMD_RD_HOLD,
    CMD_RD_ADV,
    CMD_RD_EDGE,
    CMD_RD_THR,
    CMD_RD_CNT,
    CMD_READBACK,
    CMD_TEST_LAM,
    CMD_CLR_SYS,
    CMD_CLR_LAM,
    CMD_WR_PED,
    CMD_WR_EDGE,
    CMD_WR_THR,
    CMD_WR_CTRL,
    CMD_MASK,
    CMD_UNMASK,
    CMD_ENABLE,
    CMD_TEST_RAW
  } cmd_e;

endpackage

// File: rtl/erc_decode.sv
module erc_decode
  import erc_pkg::*;
#(
  parameter int FUNC_W = 5,
  parameter int SUB_W  = 4
) (
  input  logic              strobe,
  input  logic [FUNC_W-1:0] func,
  input  logic [SUB_W-1:0]  sub,
  output cmd_e              cmd
);

  int f_i;
  int s_i;

  always_comb begin
    f_i = int'(func);
    s_i = int'(sub);
    cmd = CMD_NONE;
    if (strobe) begin
      case (f_i)
        0:  if (s_i == 0) cmd = CMD_RD_HOLD;
        1:  if (s_i < 4)  cmd = CMD_READBACK;
        2: begin
          case (s_i)
            0:       cmd = CMD_RD_ADV;
            1:       cmd = CMD_RD_EDGE;
            2:       cmd = CMD_RD_THR;
            3:       cmd = CMD_RD_CNT;
            default: cmd = CMD_NONE;
          endcase
        end
        8:  if (s_i == 0) cmd = CMD_TEST_LAM;
        9:  if (s_i == 0) cmd = CMD_CLR_SYS;
        10: if (s_i == 0) cmd = CMD_CLR_LAM;
        16: begin
          case (s_i)
            0:       cmd = CMD_WR_PED;
            1:       cmd = CMD_WR_EDGE;
            2:       cmd = CMD_WR_THR;
            3:       cmd = CMD_WR_CTRL;
            default: cmd = CMD_NONE;
          endcase
        end
        24: if (s_i == 0) cmd = CMD_MASK;
        26: begin
          if (s_i == 0)      cmd = CMD_UNMASK;
          else if (s_i == 4) cmd = CMD_ENABLE;
        end
        27: if (s_i == 0) cmd = CMD_TEST_RAW;
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/erc_buffer.sv
module erc_buffer #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_word,
  input  logic              advance,
  output logic [DATA_W-1:0] head_word,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              empty
);

  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, wr_ptr_n;
  logic [AW-1:0]     rd_ptr, rd_ptr_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              fill_ok, adv_ok;

  assign empty     = (word_cnt == '0);
  assign head_word = mem[rd_ptr];
  assign fill_ok   = fill_valid && (word_cnt != FULL_CNT) && !flush;
  assign adv_ok    = advance && !empty && !flush;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = word_cnt;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (fill_ok) wr_ptr_n = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (adv_ok)  rd_ptr_n = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      if (fill_ok && !adv_ok)      cnt_n = word_cnt + 1'b1;
      else if (adv_ok && !fill_ok) cnt_n = word_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      word_cnt <= '0;
    end else begin
      wr_ptr   <= wr_ptr_n;
      rd_ptr   <= rd_ptr_n;
      word_cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) mem[wr_ptr] <= fill_word;
  end

endmodule

// File: rtl/erc_irq.sv
module erc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic init,
  input  logic set,
  input  logic adv_read,
  input  logic last_word,
  input  logic clr_cmd,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic ext_mode,
  output logic lam_raw,
  output logic lam_mask,
  output logic lam
);

  logic raw_n, mask_n;

  always_comb begin
    raw_n = lam_raw;
    if (flush || init)                         raw_n = 1'b0;
    else if (set)                              raw_n = 1'b1;
    else if (adv_read && (!ext_mode || last_word)) raw_n = 1'b0;
    else if (clr_cmd && !ext_mode)             raw_n = 1'b0;

    mask_n = lam_mask;
    if (init)          mask_n = 1'b1;
    else if (mask_set) mask_n = 1'b1;
    else if (mask_clr) mask_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lam_raw  <= 1'b0;
      lam_mask <= 1'b1;
    end else begin
      lam_raw  <= raw_n;
      lam_mask <= mask_n;
    end
  end

  assign lam = lam_raw && !lam_mask;

endmodule

// File: rtl/evt_readout_ctrl.sv
module evt_readout_ctrl
  import erc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 64,
  parameter int PED_DEPTH = 1024,
  parameter int PED_W     = 12,
  parameter int EDGE_W    = 4,
  parameter int CTRL_W    = 5,
  parameter int FUNC_W    = 5,
  parameter int SUB_W     = 4,
  localparam int PED_AW   = $clog2(PED_DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [SUB_W-1:0]  cmd_sub,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              crate_clear,
  input  logic              crate_init,
  input  logic              ext_lam_sel,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_word,
  input  logic              event_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              q_resp,
  output logic              lam,
  output logic              busy,
  output logic              ped_we,
  output logic [PED_AW-1:0] ped_addr,
  output logic [PED_W-1:0]  ped_wdata,
  output logic [EDGE_W-1:0] cfg_edge,
  output logic [DATA_W-1:0] cfg_thresh,
  output logic [CTRL_W-1:0] cfg_ctrl
);

  localparam logic [PED_AW-1:0] PED_LAST = PED_AW'(PED_DEPTH - 1);

  cmd_e              cmd;
  logic              flush, ped_clr, adv_req;
  logic [DATA_W-1:0] head_word;
  logic [CNT_W-1:0]  word_cnt;
  logic              empty;
  logic              lam_raw, lam_mask;

  logic [EDGE_W-1:0] edge_n;
  logic [DATA_W-1:0] thresh_n;
  logic [CTRL_W-1:0] ctrl_n;
  logic              edge_en, thresh_en, ctrl_en;
  logic [PED_AW-1:0] ped_ptr, ped_ptr_n;
  logic              busy_n;
  logic [DATA_W-1:0] rd_n;
  logic              q_n;

  erc_decode #(.FUNC_W(FUNC_W), .SUB_W(SUB_W)) u_decode (
    .strobe (cmd_strobe),
    .func   (cmd_func),
    .sub    (cmd_sub),
    .cmd    (cmd)
  );

  assign flush   = crate_clear || crate_init || (cmd == CMD_CLR_SYS) || (cmd == CMD_ENABLE);
  assign ped_clr = crate_clear || crate_init || (cmd == CMD_CLR_SYS);
  assign adv_req = (cmd == CMD_RD_ADV);

  erc_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buffer (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fill_valid (fill_valid),
    .fill_word  (fill_word),
    .advance    (adv_req),
    .head_word  (head_word),
    .word_cnt   (word_cnt),
    .empty      (empty)
  );

  erc_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .init      (crate_init),
    .set       (event_done),
    .adv_read  (adv_req && !empty),
    .last_word (word_cnt == CNT_W'(1)),
    .clr_cmd   (cmd == CMD_CLR_LAM),
    .mask_set  (cmd == CMD_MASK),
    .mask_clr  (cmd == CMD_UNMASK),
    .ext_mode  (ext_lam_sel),
    .lam_raw   (lam_raw),
    .lam_mask  (lam_mask),
    .lam       (lam)
  );

  // configuration registers: next state and enables
  always_comb begin
    edge_en   = (cmd == CMD_WR_EDGE);
    thresh_en = (cmd == CMD_WR_THR);
    ctrl_en   = (cmd == CMD_WR_CTRL);
    edge_n    = wr_data[EDGE_W-1:0];
    thresh_n  = wr_data;
    ctrl_n    = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_edge   <= '0;
      cfg_thresh <= '0;
      cfg_ctrl   <= '0;
    end else begin
      if (edge_en)   cfg_edge   <= edge_n;
      if (thresh_en) cfg_thresh <= thresh_n;
      if (ctrl_en)   cfg_ctrl   <= ctrl_n;
    end
  end

  // pedestal write port
  assign ped_we    = (cmd == CMD_WR_PED);
  assign ped_addr  = ped_ptr;
  assign ped_wdata = wr_data[PED_W-1:0];

  always_comb begin
    ped_ptr_n = ped_ptr;
    if (ped_clr)     ped_ptr_n = '0;
    else if (ped_we) ped_ptr_n = (ped_ptr == PED_LAST) ? '0 : ped_ptr + 1'b1;
  end

  // data-taking state
  always_comb begin
    busy_n = busy;
    if (crate_init)             busy_n = 1'b0;
    else if (cmd == CMD_ENABLE) busy_n = 1'b1;
    else if (event_done)        busy_n = 1'b0;
  end

  // response: next state
  always_comb begin
    q_n  = 1'b0;
    rd_n = rd_data;
    if (cmd_strobe) rd_n = '0;
    case (cmd)
      CMD_RD_HOLD, CMD_RD_ADV: begin
        q_n = !empty;
        if (!empty) rd_n = head_word;
      end
      CMD_RD_EDGE: begin
        q_n = !empty;
        rd_n[EDGE_W-1:0] = cfg_edge;
      end
      CMD_RD_THR: begin
        q_n  = !empty;
        rd_n = cfg_thresh;
      end
      CMD_RD_CNT: begin
        q_n = !empty;
        rd_n[CNT_W-1:0] = word_cnt;
      end
      CMD_READBACK: begin
        q_n = 1'b1;
        case (int'(cmd_sub))
          0:       rd_n[CTRL_W-1:0] = cfg_ctrl;
          1:       rd_n[EDGE_W-1:0] = cfg_edge;
          2:       rd_n = cfg_thresh;
          default: rd_n[CNT_W-1:0] = word_cnt;
        endcase
      end
      CMD_TEST_LAM: q_n = lam_raw && !lam_mask;
      CMD_TEST_RAW: q_n = lam_raw;
      CMD_WR_PED, CMD_WR_EDGE, CMD_WR_THR, CMD_WR_CTRL: q_n = 1'b1;
      default: q_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ped_ptr <= '0;
      busy    <= 1'b0;
      rd_data <= '0;
      q_resp  <= 1'b0;
    end else begin
      ped_ptr <= ped_ptr_n;
      busy    <= busy_n;
      rd_data <= rd_n;
      q_resp  <= q_n;
    end
  end

endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int FUNC_W = 5,
  parameter int SUB_W  = 4,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_strobe,
  input logic [FUNC_W-1:0] cmd_func,
  input logic [SUB_W-1:0]  cmd_sub,
  input logic              crate_clear,
  input logic              crate_init,
  input logic              event_done,
  input logic              fill_valid,
  input logic              q_resp,
  input logic              lam,
  input logic              busy,
  input logic [CNT_W-1:0]  word_cnt,
  input logic              lam_raw
);

  logic is_adv, is_enable, is_mask, known_func, no_clr;

  assign is_adv    = cmd_strobe && (int'(cmd_func) == 2)  && (int'(cmd_sub) == 0);
  assign is_enable = cmd_strobe && (int'(cmd_func) == 26) && (int'(cmd_sub) == 4);
  assign is_mask   = cmd_strobe && (int'(cmd_func) == 24) && (int'(cmd_sub) == 0);
  assign no_clr    = !crate_clear && !crate_init;
  always_comb begin
    case (int'(cmd_func))
      0, 1, 2, 8, 9, 10, 16, 24, 26, 27: known_func = 1'b1;
      default:                           known_func = 1'b0;
    endcase
  end

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_adv && word_cnt == '0 && no_clr) |=> !q_resp);

  // R2
  adv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_adv && word_cnt != '0 && !fill_valid && no_clr) |=> (word_cnt == $past(word_cnt) - 1'b1));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_done && !is_enable) |=> !busy);

  // R11
  init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crate_init |=> (!busy && !lam));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crate_clear |=> (word_cnt == '0 && !lam_raw));

  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mask && !crate_init) |=> !lam);

  // R13
  bad_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !known_func) |=> !q_resp);

  // R13
  q_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_strobe |=> !q_resp);

endmodule

bind evt_readout_ctrl erc_checker #(.FUNC_W(FUNC_W), .SUB_W(SUB_W), .CNT_W(CNT_W)) i_erc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_strobe  (cmd_strobe),
  .cmd_func    (cmd_func),
  .cmd_sub     (cmd_sub),
  .crate_clear (crate_clear),
  .crate_init  (crate_init),
  .event_done  (event_done),
  .fill_valid  (fill_valid),
  .q_resp      (q_resp),
  .lam         (lam),
  .busy        (busy),
  .word_cnt    (word_cnt),
  .lam_raw     (lam_raw)
);

// File: tb/test_evt_readout_ctrl.sv
`timescale 1ns/1ps
module test_evt_readout_ctrl;

  logic        clk;
  logic        rst_n;
  logic        cmd_strobe;
  logic [4:0]  cmd_func;
  logic [3:0]  cmd_sub;
  logic [15:0] wr_data;
  logic        crate_clear, crate_init, ext_lam_sel;
  logic        fill_valid;
  logic [15:0] fill_word;
  logic        event_done;
  logic [15:0] rd_data;
  logic        q_resp, lam, busy, ped_we;
  logic [9:0]  ped_addr;
  logic [11:0] ped_wdata;
  logic [3:0]  cfg_edge;
  logic [15:0] cfg_thresh;
  logic [4:0]  cfg_ctrl;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic strobe_seen;

  logic        exp_q[$];
  logic [15:0] exp_d[$];
  bit          exp_c[$];
  string       exp_tag[$];

  evt_readout_ctrl i_evt_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_func(cmd_func),
    .cmd_sub(cmd_sub), .wr_data(wr_data), .crate_clear(crate_clear),
    .crate_init(crate_init), .ext_lam_sel(ext_lam_sel), .fill_valid(fill_valid),
    .fill_word(fill_word), .event_done(event_done), .rd_data(rd_data),
    .q_resp(q_resp), .lam(lam), .busy(busy), .ped_we(ped_we), .ped_addr(ped_addr),
    .ped_wdata(ped_wdata), .cfg_edge(cfg_edge), .cfg_thresh(cfg_thresh),
    .cfg_ctrl(cfg_ctrl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) strobe_seen <= cmd_strobe;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && strobe_seen) begin
      if (exp_tag.size() == 0) begin
        check("R13 unexpected response", 32'd1, 32'd0);
      end else begin
        logic        q_e;
        logic [15:0] d_e;
        bit          c_e;
        string       t_e;
        q_e = exp_q.pop_front();
        d_e = exp_d.pop_front();
        c_e = exp_c.pop_front();
        t_e = exp_tag.pop_front();
        check({t_e, " q"}, {31'd0, q_resp}, {31'd0, q_e});
        if (c_e) check({t_e, " data"}, {16'd0, rd_data}, {16'd0, d_e});
      end
    end
  end

  task automatic cmd(input int f, input int a, input logic [15:0] wd,
                     input logic eq, input logic [15:0] ed, input bit cd, input string tag);
    @(negedge clk);
    cmd_func = f[4:0];
    cmd_sub = a[3:0];
    wr_data = wd;
    cmd_strobe = 1'b1;
    exp_q.push_back(eq);
    exp_d.push_back(ed);
    exp_c.push_back(cd);
    exp_tag.push_back(tag);
    @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  task automatic ped_write(input logic [15:0] wd, input int addr, input string tag);
    @(negedge clk);
    cmd_func = 5'd16;
    cmd_sub = 4'd0;
    wr_data = wd;
    cmd_strobe = 1'b1;
    exp_q.push_back(1'b1);
    exp_d.push_back(16'd0);
    exp_c.push_back(1'b0);
    exp_tag.push_back(tag);
    #1;
    check({tag, " ped_we"}, {31'd0, ped_we}, 32'd1);
    check({tag, " ped_addr"}, {22'd0, ped_addr}, addr);
    check({tag, " ped_wdata"}, {20'd0, ped_wdata}, {20'd0, wd[11:0]});
    @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  task automatic fill(input logic [15:0] w);
    @(negedge clk);
    fill_word = w;
    fill_valid = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); event_done = 1'b1;
    @(negedge clk); event_done = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); crate_clear = 1'b1;
    @(negedge clk); crate_clear = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); crate_init = 1'b1;
    @(negedge clk); crate_init = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_strobe = 1'b0; cmd_func = '0; cmd_sub = '0; wr_data = '0;
    crate_clear = 1'b0; crate_init = 1'b0; ext_lam_sel = 1'b0;
    fill_valid = 1'b0; fill_word = '0; event_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    check("R14 rd_data", {16'd0, rd_data}, 0);
    check("R14 q", {31'd0, q_resp}, 0);
    check("R14 lam", {31'd0, lam}, 0);
    check("R14 busy", {31'd0, busy}, 0);
    check("R14 cfg", {7'd0, cfg_edge, cfg_thresh, cfg_ctrl}, 0);

    // R3 empty reads
    cmd(0, 0, 0, 1'b0, 16'h0000, 1, "R3 hold empty");
    cmd(2, 0, 0, 1'b0, 16'h0000, 1, "R3 adv empty");
    cmd(2, 3, 0, 1'b0, 16'h0000, 1, "R5 count empty");

    // R4 register writes and readback
    cmd(16, 1, 16'hFFF7, 1'b1, 0, 0, "R4 wr edge");
    check("R4 edge", {28'd0, cfg_edge}, 32'h7);
    cmd(16, 2, 16'hBEEF, 1'b1, 0, 0, "R4 wr thr");
    check("R4 thr", {16'd0, cfg_thresh}, 32'hBEEF);
    cmd(16, 3, 16'h003F, 1'b1, 0, 0, "R4 wr ctrl");
    check("R4 ctrl", {27'd0, cfg_ctrl}, 32'h1F);
    cmd(2, 1, 0, 1'b0, 16'h0007, 1, "R4 rd edge");
    cmd(2, 2, 0, 1'b0, 16'hBEEF, 1, "R4 rd thr");
    cmd(1, 0, 0, 1'b1, 16'h001F, 1, "R4 rb ctrl");
    cmd(1, 1, 0, 1'b1, 16'h0007, 1, "R4 rb edge");
    cmd(1, 2, 0, 1'b1, 16'hBEEF, 1, "R4 rb thr");
    cmd(1, 3, 0, 1'b1, 16'h0000, 1, "R4 rb count");

    // R9 enable and event
    cmd(26, 4, 0, 1'b0, 0, 0, "R9 enable");
    check("R9 busy set", {31'd0, busy}, 1);
    fill(16'hA000); fill(16'hA001); fill(16'hA002);
    pulse_done();
    check("R9 busy cleared", {31'd0, busy}, 0);
    check("R8 masked lam", {31'd0, lam}, 0);
    cmd(27, 0, 0, 1'b1, 0, 0, "R8 raw test");
    cmd(8, 0, 0, 1'b0, 0, 0, "R8 masked test");
    cmd(26, 0, 0, 1'b0, 0, 0, "R8 unmask");
    check("R8 lam unmasked", {31'd0, lam}, 1);
    cmd(8, 0, 0, 1'b1, 0, 0, "R8 unmasked test");

    // R1 R2 R5 reads
    cmd(2, 3, 0, 1'b1, 16'd3, 1, "R5 count 3");
    cmd(0, 0, 0, 1'b1, 16'hA000, 1, "R1 hold");
    cmd(0, 0, 0, 1'b1, 16'hA000, 1, "R1 hold again");
    cmd(2, 0, 0, 1'b1, 16'hA000, 1, "R2 adv 0");
    check("R6 lam cleared by read", {31'd0, lam}, 0);
    cmd(2, 3, 0, 1'b1, 16'd2, 1, "R5 count 2");
    cmd(2, 0, 0, 1'b1, 16'hA001, 1, "R2 adv 1");
    cmd(2, 0, 0, 1'b1, 16'hA002, 1, "R2 adv 2");
    cmd(2, 0, 0, 1'b0, 16'h0000, 1, "R3 drained");
    cmd(2, 3, 0, 1'b0, 16'd0, 1, "R5 count 0");

    // R6 clear command
    fill(16'hC000);
    pulse_done();
    check("R6 lam set", {31'd0, lam}, 1);
    cmd(10, 0, 0, 1'b0, 0, 0, "R6 clr lam");
    check("R6 lam clr", {31'd0, lam}, 0);
    cmd(27, 0, 0, 1'b0, 0, 0, "R6 raw after clr");

    // R7 extended mode (F9 first, R10)
    ext_lam_sel = 1'b1;
    cmd(9, 0, 0, 1'b0, 0, 0, "R10 sys clear");
    cmd(2, 3, 0, 1'b0, 16'd0, 1, "R10 count after F9");
    fill(16'hB000); fill(16'hB001);
    pulse_done();
    check("R7 lam set", {31'd0, lam}, 1);
    cmd(10, 0, 0, 1'b0, 0, 0, "R7 clr ignored");
    check("R7 lam kept after F10", {31'd0, lam}, 1);
    cmd(2, 0, 0, 1'b1, 16'hB000, 1, "R7 adv first");
    check("R7 lam kept after first read", {31'd0, lam}, 1);
    cmd(2, 0, 0, 1'b1, 16'hB001, 1, "R7 adv last");
    check("R7 lam cleared at empty", {31'd0, lam}, 0);
    ext_lam_sel = 1'b0;

    // R12 pedestal writes
    pulse_clear();
    ped_write(16'hF123, 0, "R12 ped 0");
    ped_write(16'h0456, 1, "R12 ped 1");
    ped_write(16'h0789, 2, "R12 ped 2");
    cmd(9, 0, 0, 1'b0, 0, 0, "R10 F9 ped reset");
    ped_write(16'h0ABC, 0, "R10 ped restart");

    // R10 crate clear keeps busy
    cmd(26, 4, 0, 1'b0, 0, 0, "R9 enable 2");
    fill(16'hD000); fill(16'hD001);
    pulse_clear();
    check("R10 busy kept", {31'd0, busy}, 1);
    cmd(2, 3, 0, 1'b0, 16'd0, 1, "R10 count after C");
    pulse_done();
    check("R6 lam set 2", {31'd0, lam}, 1);
    pulse_clear();
    check("R10 lam cleared", {31'd0, lam}, 0);

    // R11 initialize
    cmd(26, 4, 0, 1'b0, 0, 0, "R9 enable 3");
    pulse_init();
    check("R11 busy cleared", {31'd0, busy}, 0);
    pulse_done();
    check("R11 lam masked", {31'd0, lam}, 0);
    cmd(27, 0, 0, 1'b1, 0, 0, "R11 raw set");

    // R13 invalid commands
    fill(16'hE000);
    cmd(5, 0, 0, 1'b0, 16'h0000, 1, "R13 F5");
    cmd(2, 7, 0, 1'b0, 16'h0000, 1, "R13 F2A7");
    cmd(16, 5, 16'h1234, 1'b0, 16'h0000, 1, "R13 F16A5");
    check("R13 thr unchanged", {16'd0, cfg_thresh}, 32'hBEEF);
    cmd(2, 3, 0, 1'b1, 16'd1, 1, "R13 count kept");
    cmd(0, 0, 0, 1'b1, 16'hE000, 1, "R13 head kept");

    // R8 mask control
    cmd(26, 0, 0, 1'b0, 0, 0, "R8 unmask 2");
    check("R8 lam shown", {31'd0, lam}, 1);
    cmd(24, 0, 0, 1'b0, 0, 0, "R8 mask");
    check("R8 lam hidden", {31'd0, lam}, 0);

    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", exp_tag.size(), 0);
    finish_run();
  end

endmodule